// File: doc/BRIEF.md
# Vector Compress and Expand Unit

This unit rearranges the elements of a short vector under the control of a bit mask. In compress mode it gathers the elements whose mask bit is set and places them side by side at the bottom of the result, keeping their order and clearing the positions above them. It also reports how many elements were kept. In expand mode it does the reverse. The lowest source elements are distributed, in order, into the positions whose mask bit is set, and every other position takes its value from a second, background vector.

A request is one `start_i` pulse that carries the mode, the source, the background and the mask. One cycle later the unit presents a registered result with a one-cycle `valid_o` strobe, together with the mask's population count as the length. Both operations use one shared prefix count of the mask. For each position it gives the number of set mask bits below that position, which is the destination slot in compress and the source slot in expand.

Top module: `vcx_unit`

## Requirements
- R1: In compress mode (`mode_i` = 0), the element at position i with mask bit i set appears at result position p, where p is the number of set mask bits below i. Element i occupies bits [i*ELEM_W +: ELEM_W] of every vector port.
- R2: In both modes, `len_o` equals the number of set bits in the mask of the request.
- R3: In compress mode, every result position at or above the length is zero.
- R4: In expand mode (`mode_i` = 1), source element k is placed at the position of the (k+1)-th lowest set mask bit.
- R5: In expand mode, every result position whose mask bit is clear equals the background element at that position.
- R6: `valid_o` is high in the cycle after a `start_i` cycle and low after any cycle without `start_i`. `res_o` and `len_o` hold their values when no request arrives.
- R7: After reset, `valid_o`, `len_o` and `res_o` are all zero.
- R8: An all-zero mask gives a length of 0. It gives an all-zero result in compress mode and the unchanged background in expand mode.
- R9: An all-ones mask returns the source unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe; inputs are sampled in this cycle |
| mode_i | input | 1 | 0 = compress, 1 = expand |
| src_i | input | N_ELEM*ELEM_W | Source vector |
| bg_i | input | N_ELEM*ELEM_W | Background vector for expand |
| mask_i | input | N_ELEM | Element mask, bit i for element i |
| res_o | output | N_ELEM*ELEM_W | Registered result vector |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| len_o | output | $clog2(N_ELEM+1) | Population count of the request's mask |

## Verification
The two functions that meet in the same cycle are the per-element movement of data and the length count. Both come from the same prefix count of the mask and are loaded into one register in a single cycle. Every one of the 256 masks is applied in both modes with distinct source and background patterns, and `res_o` and `len_o` are checked together against a model that walks the mask bit by bit. Requests are issued every other cycle. The cycle between requests checks that the strobe drops and that both outputs hold.

// File: rtl/vcx_pkg.sv
package vcx_pkg;

    typedef enum logic {
        VCX_PACK    = 1'b0,
        VCX_SCATTER = 1'b1
    } vcx_mode_e;

endpackage

// File: rtl/vcx_prefix_count.sv
// Exclusive prefix population count of the mask: slot i holds the number
// of set bits below position i; total holds the full count.
module vcx_prefix_count #(
    parameter int N_ELEM = 8,
    localparam int CNT_W = $clog2(N_ELEM + 1)
) (
    input  logic [N_ELEM-1:0]       mask_i,
    output logic [N_ELEM*CNT_W-1:0] pre_o,
    output logic [CNT_W-1:0]        total_o
);

    logic [CNT_W-1:0] run [N_ELEM+1];

    assign run[0] = '0;

    for (genvar i = 0; i < N_ELEM; i++) begin : g_step
        assign run[i+1] = run[i] + CNT_W'(mask_i[i]);
        assign pre_o[i*CNT_W +: CNT_W] = run[i];
    end

    assign total_o = run[N_ELEM];

endmodule

// File: rtl/vcx_pack_net.sv
// Compress network: output slot j takes the masked element whose prefix equals j.
module vcx_pack_net #(
    parameter int N_ELEM = 8,
    parameter int ELEM_W = 8,
    localparam int CNT_W = $clog2(N_ELEM + 1)
) (
    input  logic [N_ELEM*ELEM_W-1:0] src_i,
    input  logic [N_ELEM-1:0]        mask_i,
    input  logic [N_ELEM*CNT_W-1:0]  pre_i,
    output logic [N_ELEM*ELEM_W-1:0] res_o
);

    for (genvar j = 0; j < N_ELEM; j++) begin : g_slot
        logic [ELEM_W-1:0] pick;
        always_comb begin
            pick = '0;
            for (int i = 0; i < N_ELEM; i++) begin
                if (mask_i[i] && (pre_i[i*CNT_W +: CNT_W] == CNT_W'(j))) begin
                    pick = src_i[i*ELEM_W +: ELEM_W];
                end
            end
        end
        assign res_o[j*ELEM_W +: ELEM_W] = pick;
    end

endmodule

// File: rtl/vcx_scatter_net.sv
// Expand network: a masked position i takes source element prefix(i);
// an unmasked position keeps the background element.
module vcx_scatter_net #(
    parameter int N_ELEM = 8,
    parameter int ELEM_W = 8,
    localparam int CNT_W = $clog2(N_ELEM + 1)
) (
    input  logic [N_ELEM*ELEM_W-1:0] src_i,
    input  logic [N_ELEM*ELEM_W-1:0] bg_i,
    input  logic [N_ELEM-1:0]        mask_i,
    input  logic [N_ELEM*CNT_W-1:0]  pre_i,
    output logic [N_ELEM*ELEM_W-1:0] res_o
);

    for (genvar i = 0; i < N_ELEM; i++) begin : g_pos
        logic [ELEM_W-1:0] pick;
        always_comb begin
            pick = bg_i[i*ELEM_W +: ELEM_W];
            if (mask_i[i]) begin
                pick = '0;
                for (int k = 0; k < N_ELEM; k++) begin
                    if (pre_i[i*CNT_W +: CNT_W] == CNT_W'(k)) begin
                        pick = src_i[k*ELEM_W +: ELEM_W];
                    end
                end
            end
        end
        assign res_o[i*ELEM_W +: ELEM_W] = pick;
    end

endmodule

// File: rtl/vcx_unit.sv
module vcx_unit #(
    parameter int N_ELEM = 8,
    parameter int ELEM_W = 8,
    localparam int CNT_W = $clog2(N_ELEM + 1),
    localparam int VEC_W = N_ELEM * ELEM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [VEC_W-1:0]  src_i,
    input  logic [VEC_W-1:0]  bg_i,
    input  logic [N_ELEM-1:0] mask_i,
    output logic [VEC_W-1:0]  res_o,
    output logic              valid_o,
    output logic [CNT_W-1:0]  len_o
);

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] len;
        logic [VEC_W-1:0] res;
    } state_t;

    state_t state_d, state_q;

    logic [N_ELEM*CNT_W-1:0] pre;
    logic [CNT_W-1:0]        total;
    logic [VEC_W-1:0]        packed_vec;
    logic [VEC_W-1:0]        scattered_vec;
    vcx_pkg::vcx_mode_e      mode;

    assign mode = vcx_pkg::vcx_mode_e'(mode_i);

    vcx_prefix_count #(.N_ELEM(N_ELEM)) u_prefix (
        .mask_i  (mask_i),
        .pre_o   (pre),
        .total_o (total)
    );

    vcx_pack_net #(.N_ELEM(N_ELEM), .ELEM_W(ELEM_W)) u_pack (
        .src_i  (src_i),
        .mask_i (mask_i),
        .pre_i  (pre),
        .res_o  (packed_vec)
    );

    vcx_scatter_net #(.N_ELEM(N_ELEM), .ELEM_W(ELEM_W)) u_scatter (
        .src_i  (src_i),
        .bg_i   (bg_i),
        .mask_i (mask_i),
        .pre_i  (pre),
        .res_o  (scattered_vec)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        if (start_i) begin
            state_d.valid = 1'b1;
            state_d.len   = total;
            state_d.res   = (mode == vcx_pkg::VCX_SCATTER) ? scattered_vec : packed_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_o   = state_q.res;
    assign valid_o = state_q.valid;
    assign len_o   = state_q.len;

endmodule

// File: rtl/vcx_unit_chk.sv
module vcx_unit_chk #(
    parameter int N_ELEM = 8,
    parameter int ELEM_W = 8,
    localparam int CNT_W = $clog2(N_ELEM + 1),
    localparam int VEC_W = N_ELEM * ELEM_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mode_i,
    input logic [VEC_W-1:0]  src_i,
    input logic [VEC_W-1:0]  bg_i,
    input logic [N_ELEM-1:0] mask_i,
    input logic [VEC_W-1:0]  res_o,
    input logic              valid_o,
    input logic [CNT_W-1:0]  len_o
);

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);  // R6

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o);  // R6

    AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(res_o) && $stable(len_o)));  // R6

    AST_LEN_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (len_o == CNT_W'($countones($past(mask_i)))));  // R2

    AST_EMPTY_EXPAND: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i && (mask_i == '0)) |=> (res_o == $past(bg_i)));  // R8

    AST_EMPTY_PACK: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !mode_i && (mask_i == '0)) |=> (res_o == '0));  // R8

    AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (mask_i == '1)) |=> (res_o == $past(src_i)));  // R9

endmodule

bind vcx_unit vcx_unit_chk #(.N_ELEM(N_ELEM), .ELEM_W(ELEM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .mode_i  (mode_i),
    .src_i   (src_i),
    .bg_i    (bg_i),
    .mask_i  (mask_i),
    .res_o   (res_o),
    .valid_o (valid_o),
    .len_o   (len_o)
);

// File: tb/vcx_unit_test.sv
`timescale 1ns/1ps
module vcx_unit_test;

    localparam int N  = 8;
    localparam int W  = 8;
    localparam int CW = $clog2(N + 1);
    localparam int VW = N * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [VW-1:0] src_i = '0;
    logic [VW-1:0] bg_i = '0;
    logic [N-1:0]  mask_i = '0;
    logic [VW-1:0] res_o;
    logic          valid_o;
    logic [CW-1:0] len_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    vcx_unit #(.N_ELEM(N), .ELEM_W(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mode_i  (mode_i),
        .src_i   (src_i),
        .bg_i    (bg_i),
        .mask_i  (mask_i),
        .res_o   (res_o),
        .valid_o (valid_o),
        .len_o   (len_o)
    );

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] model(input logic md, input logic [N-1:0] m,
                                           input logic [VW-1:0] s, input logic [VW-1:0] b);
        logic [VW-1:0] r;
        int k;
        r = '0;
        k = 0;
        for (int i = 0; i < N; i++) begin
            if (!md) begin
                if (m[i]) begin
                    r[k*W +: W] = s[i*W +: W];
                    k++;
                end
            end else begin
                if (m[i]) begin
                    r[i*W +: W] = s[k*W +: W];
                    k++;
                end else begin
                    r[i*W +: W] = b[i*W +: W];
                end
            end
        end
        return r;
    endfunction

    task automatic run_op(input logic md, input logic [N-1:0] m, input int seed);
        logic [VW-1:0] exp;
        logic [VW-1:0] held;
        string tag;
        for (int i = 0; i < N; i++) begin
            src_i[i*W +: W] = W'(seed + 17 * i + 1);
            bg_i[i*W +: W]  = W'(8'hC0 ^ (seed * 3 + 29 * i));
        end
        mode_i  = md;
        mask_i  = m;
        start_i = 1'b1;
        exp = model(md, m, src_i, bg_i);
        @(negedge clk);
        start_i = 1'b0;
        if (m == '0)
            tag = "R8 empty mask";
        else if (m == '1)
            tag = "R9 full mask";
        else if (md)
            tag = "R4/R5 expand";
        else
            tag = "R1/R3 compress";
        chk(tag, res_o, exp);
        chk("R2 length", VW'(len_o), VW'($countones(m)));
        chk("R6 valid after start", VW'(valid_o), VW'(1));
        held = res_o;
        @(negedge clk);
        chk("R6 valid drops", VW'(valid_o), VW'(0));
        chk("R6 result holds", res_o, held);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 reset valid", VW'(valid_o), VW'(0));
        chk("R7 reset result", res_o, '0);
        chk("R7 reset length", VW'(len_o), '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            for (int md = 0; md < 2; md++) begin
                for (int m = 0; m < (1 << N); m++) begin
                    run_op(md[0], N'(m), 40 * p + m);
                end
            end
        end
        // Back-to-back requests: valid must stay high with fresh results (R6)
        for (int m = 0; m < 4; m++) begin
            logic [VW-1:0] e;
            mode_i = 1'b0;
            mask_i = N'(8'hA5 >> m);
            for (int i = 0; i < N; i++) src_i[i*W +: W] = W'(m * 11 + i);
            e = model(1'b0, mask_i, src_i, bg_i);
            start_i = 1'b1;
            @(negedge clk);
            chk("R6 back-to-back valid", VW'(valid_o), VW'(1));
            chk("R1 back-to-back result", res_o, e);
        end
        start_i = 1'b0;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule